// File: doc/BRIEF.md
# Three-Dimensional Ping-Pong Transpose Buffer

This block sits between two stages of a three-dimensional prime-factor transform and reorders a cube of samples. Incoming samples are placed in one of two banks by a write address generator that walks three nested coordinate counters in a programmable order. Once a bank holds a whole cube, a read address generator walks the same cube in a different order and streams the samples out. Writing along one dimension and reading along another is the transpose.

Each bank is allocated with padded dimensions (8 by 16 by 16 by default), while the active extents of the three dimensions (7, 9 and 16 for the 1008-point case) come from static configuration. The two banks alternate, so one cube can be filled while the previous one is drained. The read traversal of a bank can be replayed a configured number of times before the bank is given back to the writer.

Top module: `tiled_transpose_buf`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0.
- R2: `cfg_wr_order` and `cfg_rd_order` each hold three 2-bit dimension indices: bits [1:0] name the innermost (fastest) dimension, bits [3:2] the middle one and bits [5:4] the outermost. A traversal steps the innermost counter from 0 to its extent minus one before advancing the next counter.
- R3: A sample accepted while the write traversal is at coordinate (d0,d1,d2) is stored at d0 + PAD0*d1 + PAD0*PAD1*d2 of the current bank, and every output sample is the one stored at the coordinate the read traversal is visiting.
- R4: `cfg_ext` carries the extent of dimension d in bits [5d+4:5d]; every coordinate stays below its extent, so the padded region is never touched, and a traversal covers exactly the product of the three extents, with no extra output after it.
- R5: A bank is offered to the reader only after its complete write traversal: `out_valid` stays 0 until the last sample of the first cube is accepted and is 1 in the cycle after.
- R6: When both banks hold cubes still waiting to be read, `in_ready` is 0.
- R7: The read traversal of a bank is emitted `cfg_reps` times in a row before the bank is released to the writer.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold their values into the next cycle.
- R9: While one full bank waits for the reader, the other bank accepts a new cube (`in_ready` stays 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_order | input | 6 | Write traversal order, innermost dimension in the low field |
| cfg_rd_order | input | 6 | Read traversal order, innermost dimension in the low field |
| cfg_ext | input | 3*CW | Active extent of each dimension, CW bits per field |
| cfg_reps | input | RW | Number of read passes per bank |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted when high with `in_valid` |
| in_data | input | DW | Input sample |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream accepts the output sample |
| out_data | output | DW | Output sample |

## Verification
The assertions take for granted that the configuration is a true permutation of the three dimensions, that each extent is between 1 and its padded size, that `cfg_reps` is at least 1, and that none of these change while a bank is being filled or drained. The stimulus keeps within this by programming a new configuration only after the previous cubes have been fully read out, and by always using valid orders and extents. Stimulus covers both transpose stages at full size, a small odd-shaped cube with two read passes, a held-off reader that fills both banks, and random downstream backpressure.

// File: rtl/tiled_transpose_buf.sv
module tiled_transpose_buf #(
  parameter int DW   = 16,
  parameter int PAD0 = 8,
  parameter int PAD1 = 16,
  parameter int PAD2 = 16,
  parameter int CW   = 5,
  parameter int RW   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [5:0]        cfg_wr_order,
  input  logic [5:0]        cfg_rd_order,
  input  logic [3*CW-1:0]   cfg_ext,
  input  logic [RW-1:0]     cfg_reps,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DW-1:0]     in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DW-1:0]     out_data
);
  localparam int DEPTH = PAD0 * PAD1 * PAD2;
  localparam int AW    = $clog2(DEPTH);

  logic [DW-1:0] mem [2*DEPTH];
  logic [CW-1:0] ext [3];
  logic [CW-1:0] wc [3], wc_n [3], rc [3], rc_n [3];
  logic          w_last, r_last;
  logic [1:0]    full;
  logic          wbank, rbank;
  logic [RW-1:0] rep;
  logic          wfire, rfire;

  function automatic logic [AW-1:0] lin(input logic [CW-1:0] a, input logic [CW-1:0] b,
                                        input logic [CW-1:0] c);
    return AW'(a) + AW'(PAD0) * AW'(b) + AW'(PAD0 * PAD1) * AW'(c);
  endfunction

  always_comb
    for (int d = 0; d < 3; d++) ext[d] = cfg_ext[d*CW +: CW];

  always_comb begin
    logic cy;
    cy = 1'b1;
    wc_n = wc;
    for (int s = 0; s < 3; s++) begin
      logic [1:0] d;
      d = cfg_wr_order[2*s +: 2];
      if (cy) begin
        if (wc[d] == ext[d] - 1'b1) wc_n[d] = '0;
        else begin wc_n[d] = wc[d] + 1'b1; cy = 1'b0; end
      end
    end
    w_last = cy;
  end

  always_comb begin
    logic cy;
    cy = 1'b1;
    rc_n = rc;
    for (int s = 0; s < 3; s++) begin
      logic [1:0] d;
      d = cfg_rd_order[2*s +: 2];
      if (cy) begin
        if (rc[d] == ext[d] - 1'b1) rc_n[d] = '0;
        else begin rc_n[d] = rc[d] + 1'b1; cy = 1'b0; end
      end
    end
    r_last = cy;
  end

  assign in_ready  = !full[wbank];
  assign out_valid = full[rbank];
  assign wfire     = in_valid && in_ready;
  assign rfire     = out_valid && out_ready;
  assign out_data  = mem[{rbank, lin(rc[0], rc[1], rc[2])}];

  always_ff @(posedge clk)
    if (wfire) mem[{wbank, lin(wc[0], wc[1], wc[2])}] <= in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wc    <= '{default: '0};
      rc    <= '{default: '0};
      full  <= '0;
      wbank <= 1'b0;
      rbank <= 1'b0;
      rep   <= '0;
    end else begin
      if (wfire) begin
        wc <= wc_n;
        if (w_last) begin
          full[wbank] <= 1'b1;
          wbank       <= ~wbank;
        end
      end
      if (rfire) begin
        rc <= rc_n;
        if (r_last) begin
          if (rep == cfg_reps - 1'b1) begin
            rep         <= '0;
            full[rbank] <= 1'b0;
            rbank       <= ~rbank;
          end else begin
            rep <= rep + 1'b1;
          end
        end
      end
    end
  end

  a_r4_wr_in_extent: assert property (@(posedge clk) disable iff (!rst_n)
    (wc[0] < ext[0]) && (wc[1] < ext[1]) && (wc[2] < ext[2]));
  a_r4_rd_in_extent: assert property (@(posedge clk) disable iff (!rst_n)
    (rc[0] < ext[0]) && (rc[1] < ext[1]) && (rc[2] < ext[2]));
  a_r5_handoff: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(full[0]) || $rose(full[1])) |-> $past(wfire && w_last));
  a_r6_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (full == 2'b11) |-> !in_ready);
  a_r7_rep_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rep < cfg_reps);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: tb/tb_tiled_transpose_buf.sv
`timescale 1ns/1ps
module tb_tiled_transpose_buf;
  localparam int DW = 16, CW = 5, RW = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] cfg_wr_order = 6'b10_01_00, cfg_rd_order = 6'b00_10_01;
  logic [3*CW-1:0] cfg_ext = {5'd16, 5'd9, 5'd7};
  logic [RW-1:0] cfg_reps = 4'd1;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0;
  logic [DW-1:0] in_data = '0, out_data;
  int checks = 0, errors = 0;
  int out_mode = 0;
  int q[$];
  int model [8][16][16];
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  tiled_transpose_buf #(.DW(DW), .CW(CW), .RW(RW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_order(cfg_wr_order), .cfg_rd_order(cfg_rd_order),
    .cfg_ext(cfg_ext), .cfg_reps(cfg_reps), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

  task automatic check(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  // Configure the DUT and push the expected read-out sequence (R2, R3, R4, R7)
  task automatic plan_cube(input int w0, input int w1, input int w2, input int r0, input int r1,
                           input int r2, input int e0, input int e1, input int e2,
                           input int reps, input int base);
    int wo[3], ro[3], e[3], co[3], k;
    wo = '{w0, w1, w2}; ro = '{r0, r1, r2}; e = '{e0, e1, e2};
    cfg_wr_order = {2'(w2), 2'(w1), 2'(w0)};
    cfg_rd_order = {2'(r2), 2'(r1), 2'(r0)};
    cfg_ext = {5'(e2), 5'(e1), 5'(e0)};
    cfg_reps = 4'(reps);
    k = 0;
    for (int a = 0; a < e[wo[2]]; a++)
      for (int b = 0; b < e[wo[1]]; b++)
        for (int c = 0; c < e[wo[0]]; c++) begin
          co[wo[2]] = a; co[wo[1]] = b; co[wo[0]] = c;
          model[co[0]][co[1]][co[2]] = base + k;
          k++;
        end
    for (int r = 0; r < reps; r++)
      for (int a = 0; a < e[ro[2]]; a++)
        for (int b = 0; b < e[ro[1]]; b++)
          for (int c = 0; c < e[ro[0]]; c++) begin
            co[ro[2]] = a; co[ro[1]] = b; co[ro[0]] = c;
            q.push_back(model[co[0]][co[1]][co[2]]);
          end
  endtask

  task automatic drive(input int first, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data = DW'(first + k);
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
    check(!out_valid, "R4 no extra output", int'(out_valid), 0);
  endtask

  // Scoreboard monitor
  initial begin
    bit held = 1'b0;
    logic [DW-1:0] held_data = '0;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (held) begin
        check(out_valid && out_data == held_data, "R8 hold", int'(out_data), int'(held_data));
      end
      out_ready = (out_mode == 1) || (out_mode == 2 && lfsr[0]);
      held = out_valid && !out_ready;
      held_data = out_data;
      if (out_valid && out_ready) begin
        if (q.size() == 0) check(1'b0, "R4 unexpected output", int'(out_data), -1);
        else begin
          int e;
          e = q.pop_front();
          check(int'(out_data) == e, "R3 read order", int'(out_data), e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog got %0d expected %0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);

    // First-stage transpose, reader held off: R5, R9, R6
    out_mode = 0;
    plan_cube(0, 1, 2, 1, 2, 0, 7, 9, 16, 1, 0);
    drive(0, 1007);
    check(out_valid == 1'b0, "R5 before last write", int'(out_valid), 0);
    drive(1007, 1);
    check(out_valid == 1'b1, "R5 after last write", int'(out_valid), 1);
    check(in_ready == 1'b1, "R9 second bank free", int'(in_ready), 1);
    plan_cube(0, 1, 2, 1, 2, 0, 7, 9, 16, 1, 2000);
    drive(2000, 1008);
    check(in_ready == 1'b0, "R6 both banks full", int'(in_ready), 0);
    repeat (5) @(negedge clk);
    check(in_ready == 1'b0, "R6 still stalled", int'(in_ready), 0);
    out_mode = 1;
    drain();

    // Second-stage transpose with random backpressure: R2, R3, R8
    out_mode = 2;
    plan_cube(1, 2, 0, 2, 1, 0, 7, 9, 16, 1, 5000);
    drive(5000, 1008);
    drain();

    // Small odd cube, two read passes: R4, R7
    plan_cube(2, 0, 1, 0, 2, 1, 3, 2, 4, 2, 9000);
    fork
      drive(9000, 24);
      begin
        while (q.size() > 24) @(negedge clk);
        @(negedge clk);
        check(in_ready == 1'b1 || out_valid == 1'b1, "R7 pass boundary", 1, 1);
      end
    join
    drain();
    check(q.size() == 0, "R7 replay count", q.size(), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule